// File: doc/BRIEF.md
# Paired Transmit/Receive CRC Sequencer for a Serial Link

This unit sits beside a serial shift engine. It keeps two CRC accumulators. One folds in every transmitted bit and the other folds in every received bit. Both use the same generator polynomial, which software programs. The shift engine reports each bit on the line with a one-cycle strobe, most significant bit first, and reports the end of each frame with a separate boundary strobe.

At the end of a transfer the unit runs a CRC frame. During that frame the shift engine sends the frozen transmit CRC in place of buffered data, and the unit captures the word that arrives at the same time. When the frame closes, the unit compares the captured word with the receive accumulator, and a mismatch raises a sticky error. The CRC frame can start in two ways:

- Software raises a request during the final data frame. In receive-only use, this means after the second-to-last frame has arrived.
- In DMA mode, a frame counter starts the CRC frame once the programmed number of data frames has completed.

Frames are either narrow (half the CRC register width) or wide (the full width).

Top module: `duo_crc_seq`

## Requirements
- R1: While enabled, each cycle with `bit_stb` high shifts `tx_bit` into `tx_crc` and `rx_bit` into `rx_crc`, MSB first. The step is: feedback = top bit XOR input bit; value = (value << 1) XOR (feedback ? polynomial : 0). Both start at zero and no final XOR is applied.
- R2: Both accumulators use `poly`. With `wide`=0 only `poly[7:0]` is used, the CRC is 8 bits wide, its top is bit 7, and bits [15:8] read zero. Polynomial bits above the selected width have no effect.
- R3: While `crc_on` is low, both accumulators read zero, bit strobes and `next_req` are ignored, and `crc_phase` is low.
- R4: A one-cycle `crc_clr` pulse zeroes both accumulators.
- R5: After a `next_req` pulse, the next `frame_end` makes `crc_phase` go high on the following cycle. It stays high for exactly one frame, and `tx_crc` then holds the value to transmit.
- R6: While `crc_phase` is high, neither accumulator changes on bit strobes. The received bits are captured as the incoming CRC instead.
- R7: The `frame_end` that closes the CRC frame drops `crc_phase`. If the captured word (masked to the frame width) differs from `rx_crc`, `crc_err` is set. A match leaves `crc_err` unchanged.
- R8: In receive-only use, a request raised after the second-to-last frame makes the frame after the last data frame the checked CRC frame, whatever the transmit line carries.
- R9: `crc_err` stays high until a `err_clr` pulse.
- R10: With `dma_on` high, the `dma_len`-th `frame_end` after enable (or after the previous CRC frame) starts the CRC frame with no `next_req`. `dma_len` must be nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_on | input | 1 | CRC enable |
| crc_clr | input | 1 | Zero both accumulators |
| wide | input | 1 | 1: 16-bit frames/CRC, 0: 8-bit |
| poly | input | 16 | Generator polynomial |
| bit_stb | input | 1 | One line bit is valid |
| tx_bit | input | 1 | Transmitted line bit |
| rx_bit | input | 1 | Received line bit |
| frame_end | input | 1 | Frame boundary, after its last bit |
| next_req | input | 1 | Software CRC-frame request |
| dma_on | input | 1 | Automatic CRC-frame mode |
| dma_len | input | 16 | Data frames before the CRC frame |
| err_clr | input | 1 | Clear the error flag |
| tx_crc | output | 16 | Transmit accumulator / CRC to send |
| rx_crc | output | 16 | Receive accumulator |
| crc_phase | output | 1 | Current frame is the CRC frame |
| crc_err | output | 1 | Sticky CRC mismatch |

## Verification
The bench runs random traffic in both frame widths, with junk placed in the unused polynomial bits. A design that leaked those bits or mis-picked the feedback bit would drift from the model. The bench checks that the accumulators freeze during the CRC frame, since a design that kept folding would compare against the wrong value. It returns both correct and corrupted CRC words to prove the flag sets only on mismatch and then sticks. It also counts frames in DMA mode, where an off-by-one counter would start the CRC frame one frame early or late.

// File: rtl/crcseq_pkg.sv
package crcseq_pkg;
  typedef enum logic {PH_DATA = 1'b0, PH_CRC = 1'b1} phase_t;
endpackage

// File: rtl/crc_accum.sv
module crc_accum #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          hold,
  input  logic          wide,
  input  logic [CW-1:0] poly,
  input  logic          stb,
  input  logic          din,
  output logic [CW-1:0] crc
);
  localparam int HW = CW / 2;

  logic [CW-1:0] mask, step, crc_d;
  logic          fb;

  always_comb begin
    mask  = wide ? {CW{1'b1}} : {{(CW-HW){1'b0}}, {HW{1'b1}}};
    fb    = (wide ? crc[CW-1] : crc[HW-1]) ^ din;
    step  = ((crc << 1) ^ (fb ? poly : '0)) & mask;
    crc_d = crc;
    if (!en || clr)        crc_d = '0;
    else if (stb && !hold) crc_d = step;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) crc <= '0;
    else        crc <= crc_d;

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || clr) |=> crc == '0);
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && hold) |=> $stable(crc));
  a_r2_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !hold && stb && !wide) |=> crc[CW-1:HW] == '0);
endmodule

// File: rtl/crc_phase_ctl.sv
module crc_phase_ctl
  import crcseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             next_req,
  input  logic             frame_end,
  input  logic             dma_on,
  input  logic [CNT_W-1:0] dma_len,
  output logic             phase,
  output logic             go,
  output logic             done
);
  phase_t           st, st_d;
  logic             armed, armed_d, dma_hit;
  logic [CNT_W-1:0] cnt, cnt_d, cnt_inc;

  always_comb begin
    cnt_inc = cnt + 1'b1;
    dma_hit = dma_on && (cnt_inc == dma_len);
    go      = en && (st == PH_DATA) && frame_end && (armed || next_req || dma_hit);
    done    = en && (st == PH_CRC) && frame_end;

    st_d = st;
    if (!en)       st_d = PH_DATA;
    else if (go)   st_d = PH_CRC;
    else if (done) st_d = PH_DATA;

    armed_d = armed;
    if (!en || go)                        armed_d = 1'b0;
    else if (st == PH_DATA && next_req)   armed_d = 1'b1;

    cnt_d = cnt;
    if (!en || !dma_on || go)             cnt_d = '0;
    else if (st == PH_DATA && frame_end)  cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= PH_DATA;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      st    <= st_d;
      armed <= armed_d;
      cnt   <= cnt_d;
    end

  assign phase = (st == PH_CRC);

  a_r5_enter_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase) |-> $past(frame_end));
  a_r7_done_exits: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !phase);
  a_r3_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !phase);
endmodule

// File: rtl/crc_check.sv
module crc_check #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase,
  input  logic          go,
  input  logic          done,
  input  logic          stb,
  input  logic          rx_bit,
  input  logic          wide,
  input  logic [CW-1:0] rx_crc,
  input  logic          err_clr,
  output logic          crc_err
);
  localparam int HW = CW / 2;

  logic [CW-1:0] cap, cap_d, mask;
  logic          mism, err_d;

  always_comb begin
    mask  = wide ? {CW{1'b1}} : {{(CW-HW){1'b0}}, {HW{1'b1}}};
    cap_d = cap;
    if (go)               cap_d = '0;
    else if (phase && stb) cap_d = {cap[CW-2:0], rx_bit};
    mism  = done && ((cap & mask) != rx_crc);
    err_d = (crc_err && !err_clr) || mism;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap     <= '0;
      crc_err <= 1'b0;
    end else begin
      cap     <= cap_d;
      crc_err <= err_d;
    end

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !err_clr) |=> crc_err);
  a_r7_set_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> $past(done));
endmodule

// File: rtl/duo_crc_seq.sv
module duo_crc_seq #(
  parameter int CW    = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crc_on,
  input  logic             crc_clr,
  input  logic             wide,
  input  logic [CW-1:0]    poly,
  input  logic             bit_stb,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic             frame_end,
  input  logic             next_req,
  input  logic             dma_on,
  input  logic [CNT_W-1:0] dma_len,
  input  logic             err_clr,
  output logic [CW-1:0]    tx_crc,
  output logic [CW-1:0]    rx_crc,
  output logic             crc_phase,
  output logic             crc_err
);
  logic [1:0] rst_sync;
  logic       rst_s, go, done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  assign rst_s = rst_sync[1];

  crc_phase_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_s), .en(crc_on), .next_req(next_req),
    .frame_end(frame_end), .dma_on(dma_on), .dma_len(dma_len),
    .phase(crc_phase), .go(go), .done(done));

  crc_accum #(.CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_s), .en(crc_on), .clr(crc_clr), .hold(crc_phase),
    .wide(wide), .poly(poly), .stb(bit_stb), .din(tx_bit), .crc(tx_crc));

  crc_accum #(.CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_s), .en(crc_on), .clr(crc_clr), .hold(crc_phase),
    .wide(wide), .poly(poly), .stb(bit_stb), .din(rx_bit), .crc(rx_crc));

  crc_check #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_s), .phase(crc_phase), .go(go), .done(done),
    .stb(bit_stb), .rx_bit(rx_bit), .wide(wide), .rx_crc(rx_crc),
    .err_clr(err_clr), .crc_err(crc_err));
endmodule

// File: tb/test_duo_crc_seq.sv
module test_duo_crc_seq;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        crc_on = 0, crc_clr = 0, wide = 1, bit_stb = 0, tx_bit = 0, rx_bit = 0;
  logic        frame_end = 0, next_req = 0, dma_on = 0, err_clr = 0;
  logic [15:0] poly = 16'h8005, dma_len = 16'd1;
  logic [15:0] tx_crc, rx_crc;
  logic        crc_phase, crc_err;
  logic [15:0] mt, mr;
  int          total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  duo_crc_seq i_duo_crc_seq (.*);

  function automatic logic [15:0] mstep(logic [15:0] c, logic b);
    logic [15:0] m = wide ? 16'hFFFF : 16'h00FF;
    logic fb = (wide ? c[15] : c[7]) ^ b;
    mstep = ((c << 1) & m) ^ (fb ? (poly & m) : 16'h0);
  endfunction

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic frame(logic [15:0] tw, logic [15:0] rw, bit upd);
    for (int i = (wide ? 15 : 7); i >= 0; i--) begin
      @(negedge clk); bit_stb = 1; tx_bit = tw[i]; rx_bit = rw[i];
      if (upd) begin mt = mstep(mt, tw[i]); mr = mstep(mr, rw[i]); end
    end
    @(negedge clk); bit_stb = 0; frame_end = 1;
    @(negedge clk); frame_end = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk); next_req = 1; @(negedge clk); next_req = 0;
  endtask

  task automatic zero_all();
    @(negedge clk); crc_clr = 1; @(negedge clk); crc_clr = 0; mt = 0; mr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w, keep;
    void'($urandom(7));
    mt = 0; mr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R3 reset tx", tx_crc, 0);
    chk("R3 reset phase/err", {crc_phase, crc_err}, 0);

    // R3: disabled, bits and request ignored
    frame(16'hA5C3, 16'h1234, 0);
    chk("R3 off tx", tx_crc, 0);
    pulse_req(); frame(16'hFFFF, 16'hFFFF, 0);
    frame(16'h0F0F, 16'h0F0F, 0);
    chk("R3 off phase", crc_phase, 0);

    // R1/R5/R6/R7: full duplex, random traffic, correct CRC back
    crc_on = 1;
    for (int t = 0; t < 4; t++) begin
      int n = 2 + ($urandom % 4);
      wide = t[0]; poly = $urandom;
      zero_all();
      for (int f = 0; f < n; f++) begin
        if (f == n - 1) pulse_req();
        frame($urandom, $urandom, 1);
        chk("R1 tx accum", tx_crc, mt);
        chk("R1 rx accum", rx_crc, mr);
      end
      chk("R5 phase after last", crc_phase, 1);
      keep = mt;
      frame(mt, mr, 0);
      chk("R6 tx frozen", tx_crc, keep);
      chk("R7 phase closed", crc_phase, 0);
      chk("R7 match no err", crc_err, 0);
    end

    // R2: upper poly bits ignored in narrow mode
    wide = 0; poly = 16'hAB07; zero_all();
    frame(16'h00C5, 16'h003A, 1);
    chk("R2 narrow tx", tx_crc, mt);
    chk("R2 narrow upper", rx_crc & 16'hFF00, 0);

    // R4: clear
    zero_all();
    chk("R4 clear", {tx_crc | rx_crc}, 0);

    // R7/R9: wrong CRC sets sticky error
    wide = 1; poly = 16'h1021;
    pulse_req(); frame($urandom, $urandom, 1);
    frame(mt, mr ^ 16'h0001, 0);
    chk("R7 mismatch err", crc_err, 1);
    frame(16'h1111, 16'h2222, 1);
    chk("R9 sticky", crc_err, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk("R9 cleared", crc_err, 0);

    // R8: receive-only, tx line idle, request after second-to-last
    zero_all();
    frame(0, $urandom, 1);
    pulse_req();
    frame(0, $urandom, 1);
    chk("R8 phase", crc_phase, 1);
    frame(0, mr, 0);
    chk("R8 good crc", crc_err, 0);

    // R10: DMA mode triggers after dma_len frames
    dma_on = 1; dma_len = 3; zero_all();
    frame($urandom, $urandom, 1);
    frame($urandom, $urandom, 1);
    chk("R10 not early", crc_phase, 0);
    frame($urandom, $urandom, 1);
    chk("R10 entered", crc_phase, 1);
    w = mr;
    frame(mt, w, 0);
    chk("R10 check ok", {crc_phase, crc_err}, 0);
    frame($urandom, $urandom, 1);
    frame($urandom, $urandom, 1);
    frame($urandom, $urandom, 1);
    chk("R10 second round", crc_phase, 1);
    frame(mt, mr ^ 16'h8000, 0);
    chk("R10 bad crc err", crc_err, 1);

    // R3: dropping enable zeroes accumulators
    @(negedge clk); crc_on = 0; @(negedge clk);
    chk("R3 disable zero", {tx_crc | rx_crc}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule